// File: doc/BRIEF.md
# RFID Write Command Validator

When a passive tag's downlink ends, this block decides what to do with the command frame it just received. The gap decoder upstream supplies several inputs at the same time: the number of bits received, a flag for any pulse whose field-clock count was neither a valid one nor a valid zero, and the fields already parsed from the frame. Those fields are the opcode, the target page, the received password, the lock bit, a 32-bit data word and a 3-bit block address. The configuration bit that selects password mode is also an input.

The block reads the addressed block's lock bit through a small read port. The stored password word (the contents of block 7) arrives on its own input.

The frame length that the block accepts depends on the command type and on password mode. The cost of an error depends on where it is found:
- A malformed frame sends the tag back to reading the whole page, starting at block 1.
- A well-formed write to a locked block only sends the tag into looping on that block.
- A well-formed write to an unlocked block starts programming.

One clock after the end-of-frame strobe, the block issues exactly one decision pulse. The page, address, data and lock values that go with the decision are held on the outputs until the next frame.

Top module: `wr_cmd_check`

## Requirements
- R1: Exactly one of `start_prog_o`, `regular_read_o` or `block_read_o` pulses high for one cycle, in the clock after the clock where `eof_i` is sampled high. No decision pulse appears in any other cycle.
- R2: The opcode encoding is as follows:
  - `10` is an access command (write, direct access or wake-up, chosen by the length).
  - `11` is a page regular-read.
  - `00` is a reset.
  - `01` is always an error.
- R3: With password mode on, an access frame of exactly 70 bits is a password write. With password mode off, a 70-bit frame is an error.
- R4: With password mode off, an access frame of exactly 38 bits is a standard write.
- R5: A direct access frame is 38 bits with password mode on, or 6 bits with password mode off. A valid direct access frame gives `block_read_o` with `addr_o` equal to the received address. With password mode off, the received password is ignored.
- R6: With password mode on, an access frame of 34 bits is a wake-up, and it gives `regular_read_o` for the received page. With password mode off, a 34-bit frame is an error.
- R7: Reset and page regular-read are valid only as 2-bit frames:
  - A reset gives `regular_read_o` on page 0.
  - A page regular-read gives `regular_read_o` on the received page.
  - An access opcode in a 2-bit frame is an error.
- R8: With password mode on, if a password-bearing frame (70, 38 or 34 bits) carries a password different from `stored_pwd_i`, the frame is an error.
- R9: When `pulse_err_i` is high at end of frame, the frame is an error, whatever its length.
- R10: Any error gives `regular_read_o` with `page_o` equal to the received page and `addr_o` equal to 1.
- R11: A valid password write or standard write gives `start_prog_o` when the addressed block's lock bit is clear. When that lock bit is set, it gives `block_read_o` instead, with `addr_o` equal to the received address.
- R12: On every decision, `data_o` and `lock_o` take the values received with the frame. `mem_addr_o` always follows `addr_i`.
- R13: Between decisions, `page_o`, `addr_o`, `data_o` and `lock_o` stay unchanged whatever the inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| eof_i | input | 1 | End-of-frame strobe, one cycle |
| bit_cnt_i | input | 7 | Number of bits received in the frame |
| pulse_err_i | input | 1 | Some pulse had an invalid field-clock count |
| opcode_i | input | 2 | Received opcode |
| page_i | input | 1 | Received page select |
| pwd_mode_i | input | 1 | Password mode configuration bit |
| pwd_i | input | 32 | Received password |
| lock_i | input | 1 | Received lock bit |
| data_i | input | 32 | Received data word |
| addr_i | input | 3 | Received block address |
| stored_pwd_i | input | 32 | Stored password word (block 7) |
| mem_addr_o | output | 3 | Lock-bit read address |
| mem_lock_i | input | 1 | Lock bit of the block at `mem_addr_o` |
| start_prog_o | output | 1 | Decision pulse: start programming |
| regular_read_o | output | 1 | Decision pulse: regular read of page |
| block_read_o | output | 1 | Decision pulse: loop on block read |
| page_o | output | 1 | Page for the decision |
| addr_o | output | 3 | Block address for the decision |
| data_o | output | 32 | Data word latched with the decision |
| lock_o | output | 1 | Lock bit latched with the decision |

## Verification
Every decision and its latched fields are due one clock after the `eof_i` strobe, and `mem_addr_o` follows `addr_i` within the same cycle. The bench drives each frame on a falling edge with the strobe high for one cycle, then checks the pulse and fields at the next falling edge. It then scrambles the inputs with the strobe low and checks, one cycle later, that no pulse appears and that the latched fields have not moved.

// File: rtl/wcv_pkg.sv
package wcv_pkg;

    localparam int OP_W   = 2;
    localparam int LOCK_W = 1;

    typedef enum logic [1:0] {
        OP_RESET  = 2'b00,
        OP_UNDEF  = 2'b01,
        OP_ACCESS = 2'b10,
        OP_PAGERD = 2'b11
    } op_e;

    typedef enum logic [2:0] {
        K_ERR,
        K_PWD_WR,
        K_STD_WR,
        K_DA_PWD,
        K_DA,
        K_WAKE,
        K_RST,
        K_PGRD
    } kind_e;

endpackage

// File: rtl/frame_classify.sv
module frame_classify
    import wcv_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 3,
    parameter int CNT_W  = 7
) (
    input  logic [OP_W-1:0]  opcode_i,
    input  logic [CNT_W-1:0] bit_cnt_i,
    input  logic             pwd_mode_i,
    output kind_e            kind_o
);
    localparam int LEN_SHORT  = OP_W;
    localparam int LEN_DA     = OP_W + LOCK_W + ADDR_W;
    localparam int LEN_WAKE   = OP_W + DATA_W;
    localparam int LEN_STD    = OP_W + LOCK_W + DATA_W + ADDR_W;
    localparam int LEN_DA_PWD = OP_W + DATA_W + LOCK_W + ADDR_W;
    localparam int LEN_PWD_WR = OP_W + DATA_W + LOCK_W + DATA_W + ADDR_W;

    always_comb begin
        kind_o = K_ERR;
        unique case (op_e'(opcode_i))
            OP_RESET:  if (bit_cnt_i == CNT_W'(LEN_SHORT)) kind_o = K_RST;
            OP_PAGERD: if (bit_cnt_i == CNT_W'(LEN_SHORT)) kind_o = K_PGRD;
            OP_ACCESS: begin
                if (pwd_mode_i) begin
                    if      (bit_cnt_i == CNT_W'(LEN_PWD_WR)) kind_o = K_PWD_WR;
                    else if (bit_cnt_i == CNT_W'(LEN_DA_PWD)) kind_o = K_DA_PWD;
                    else if (bit_cnt_i == CNT_W'(LEN_WAKE))   kind_o = K_WAKE;
                end else begin
                    if      (bit_cnt_i == CNT_W'(LEN_STD))    kind_o = K_STD_WR;
                    else if (bit_cnt_i == CNT_W'(LEN_DA))     kind_o = K_DA;
                end
            end
            default:   kind_o = K_ERR;
        endcase
    end
endmodule

// File: rtl/pwd_compare.sv
module pwd_compare #(
    parameter int DATA_W = 32,
    parameter int LANE_W = 8
) (
    input  logic [DATA_W-1:0] rx_pwd_i,
    input  logic [DATA_W-1:0] ref_pwd_i,
    output logic              match_o
);
    localparam int LANES = (DATA_W + LANE_W - 1) / LANE_W;
    localparam int PAD_W = LANES * LANE_W;

    logic [PAD_W-1:0] rx_pad, ref_pad;
    logic [LANES-1:0] lane_eq;

    assign rx_pad  = PAD_W'(rx_pwd_i);
    assign ref_pad = PAD_W'(ref_pwd_i);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_eq[g] = (rx_pad[g*LANE_W +: LANE_W] == ref_pad[g*LANE_W +: LANE_W]);
    end

    assign match_o = &lane_eq;
endmodule

// File: rtl/wr_cmd_check.sv
module wr_cmd_check
    import wcv_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 3,
    parameter int CNT_W  = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              eof_i,
    input  logic [CNT_W-1:0]  bit_cnt_i,
    input  logic              pulse_err_i,
    input  logic [OP_W-1:0]   opcode_i,
    input  logic              page_i,
    input  logic              pwd_mode_i,
    input  logic [DATA_W-1:0] pwd_i,
    input  logic              lock_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] stored_pwd_i,
    output logic [ADDR_W-1:0] mem_addr_o,
    input  logic              mem_lock_i,
    output logic              start_prog_o,
    output logic              regular_read_o,
    output logic              block_read_o,
    output logic              page_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic [DATA_W-1:0] data_o,
    output logic              lock_o
);
    localparam logic [ADDR_W-1:0] FIRST_BLK = ADDR_W'(1);

    typedef struct packed {
        logic              prog;
        logic              rread;
        logic              bread;
        logic              page;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
        logic              lock;
    } dec_t;

    dec_t  st_d, st_q;
    kind_e kind;
    logic  pwd_ok;
    logic  needs_pwd;
    logic  frame_err;

    frame_classify #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_class (
        .opcode_i   (opcode_i),
        .bit_cnt_i  (bit_cnt_i),
        .pwd_mode_i (pwd_mode_i),
        .kind_o     (kind)
    );

    pwd_compare #(.DATA_W(DATA_W), .LANE_W(8)) u_pwd (
        .rx_pwd_i  (pwd_i),
        .ref_pwd_i (stored_pwd_i),
        .match_o   (pwd_ok)
    );

    assign mem_addr_o = addr_i;
    assign needs_pwd  = (kind == K_PWD_WR) || (kind == K_DA_PWD) || (kind == K_WAKE);
    assign frame_err  = pulse_err_i || (kind == K_ERR) || (needs_pwd && !pwd_ok);

    always_comb begin
        st_d       = st_q;
        st_d.prog  = 1'b0;
        st_d.rread = 1'b0;
        st_d.bread = 1'b0;
        if (eof_i) begin
            st_d.data = data_i;
            st_d.lock = lock_i;
            st_d.page = page_i;
            st_d.addr = FIRST_BLK;
            if (frame_err) begin
                st_d.rread = 1'b1;
            end else begin
                unique case (kind)
                    K_PWD_WR, K_STD_WR: begin
                        st_d.addr = addr_i;
                        if (mem_lock_i) st_d.bread = 1'b1;
                        else            st_d.prog  = 1'b1;
                    end
                    K_DA_PWD, K_DA: begin
                        st_d.addr  = addr_i;
                        st_d.bread = 1'b1;
                    end
                    K_RST: begin
                        st_d.page  = 1'b0;
                        st_d.rread = 1'b1;
                    end
                    default: st_d.rread = 1'b1;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign start_prog_o   = st_q.prog;
    assign regular_read_o = st_q.rread;
    assign block_read_o   = st_q.bread;
    assign page_o         = st_q.page;
    assign addr_o         = st_q.addr;
    assign data_o         = st_q.data;
    assign lock_o         = st_q.lock;

    // R1
    dec_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({start_prog_o, regular_read_o, block_read_o}));

    // R1
    dec_after_eof_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eof_i |=> ($countones({start_prog_o, regular_read_o, block_read_o}) == 1));

    // R1
    no_spurious_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !eof_i |=> !(start_prog_o || regular_read_o || block_read_o));

    // R9
    pulse_err_fallback_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eof_i && pulse_err_i) |=> (regular_read_o && addr_o == FIRST_BLK));

    // R11
    locked_no_prog_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eof_i && mem_lock_i) |=> !start_prog_o);

    // R13
    fields_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !eof_i |=> $stable({page_o, addr_o, data_o, lock_o}));
endmodule

// File: tb/wr_cmd_check_tb_top.sv
`timescale 1ns/1ps
module wr_cmd_check_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        eof_i = 1'b0;
    logic [6:0]  bit_cnt_i = '0;
    logic        pulse_err_i = 1'b0;
    logic [1:0]  opcode_i = '0;
    logic        page_i = 1'b0;
    logic        pwd_mode_i = 1'b0;
    logic [31:0] pwd_i = '0;
    logic        lock_i = 1'b0;
    logic [31:0] data_i = '0;
    logic [2:0]  addr_i = '0;
    logic [31:0] stored_pwd_i = 32'hA5C3_1E07;
    logic [2:0]  mem_addr_o;
    logic        mem_lock_i;
    logic        start_prog_o, regular_read_o, block_read_o, page_o, lock_o;
    logic [2:0]  addr_o;
    logic [31:0] data_o;

    logic lock_mem [8];
    int   n_checks = 0;
    int   n_errors = 0;
    bit   done = 1'b0;

    typedef struct {
        bit        sp, rr, br, page;
        bit [2:0]  addr;
        string     tag;
    } exp_t;

    always #2.5 clk = ~clk;
    assign mem_lock_i = lock_mem[mem_addr_o];

    wr_cmd_check dut_i (
        .clk(clk), .rst_n(rst_n), .eof_i(eof_i), .bit_cnt_i(bit_cnt_i),
        .pulse_err_i(pulse_err_i), .opcode_i(opcode_i), .page_i(page_i),
        .pwd_mode_i(pwd_mode_i), .pwd_i(pwd_i), .lock_i(lock_i), .data_i(data_i),
        .addr_i(addr_i), .stored_pwd_i(stored_pwd_i), .mem_addr_o(mem_addr_o),
        .mem_lock_i(mem_lock_i), .start_prog_o(start_prog_o),
        .regular_read_o(regular_read_o), .block_read_o(block_read_o),
        .page_o(page_o), .addr_o(addr_o), .data_o(data_o), .lock_o(lock_o)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic exp_t model(input bit [1:0] op, input int cnt, input bit pm,
                                   input bit [31:0] pw, input bit pe, input bit pg,
                                   input bit [2:0] ad, input bit lk_mem);
        exp_t e;
        int   kind = 0; // 0 err,1 pwd wr,2 std wr,3 da pwd,4 da,5 wake,6 rst,7 page rd
        bit   err;
        if (op == 2'b00 && cnt == 2) kind = 6;
        else if (op == 2'b11 && cnt == 2) kind = 7;
        else if (op == 2'b10) begin
            if (pm) kind = (cnt == 70) ? 1 : (cnt == 38) ? 3 : (cnt == 34) ? 5 : 0;
            else    kind = (cnt == 38) ? 2 : (cnt == 6) ? 4 : 0;
        end
        err = pe || kind == 0 || ((kind == 1 || kind == 3 || kind == 5) && pw != stored_pwd_i);
        e.sp = 0; e.rr = 0; e.br = 0; e.page = pg; e.addr = 3'd1;
        if (err) begin
            e.rr = 1; e.tag = "R10";
        end else if (kind == 1 || kind == 2) begin
            e.addr = ad;
            if (lk_mem) begin e.br = 1; e.tag = "R11"; end
            else begin e.sp = 1; e.tag = (kind == 1) ? "R3" : "R4"; end
        end else if (kind == 3 || kind == 4) begin
            e.addr = ad; e.br = 1; e.tag = "R5";
        end else if (kind == 5) begin
            e.rr = 1; e.tag = "R6";
        end else begin
            e.rr = 1; e.tag = "R7";
            if (kind == 6) e.page = 0;
        end
        return e;
    endfunction

    task automatic frame(input bit [1:0] op, input int cnt, input bit pm, input bit [31:0] pw,
                         input bit pe, input bit pg, input bit [2:0] ad, input bit [31:0] dt,
                         input bit lk);
        exp_t e;
        logic [37:0] snap;
        @(negedge clk);
        opcode_i = op; bit_cnt_i = 7'(cnt); pwd_mode_i = pm; pwd_i = pw;
        pulse_err_i = pe; page_i = pg; addr_i = ad; data_i = dt; lock_i = lk;
        eof_i = 1'b1;
        #1;
        check(mem_addr_o == ad, "R12", "mem_addr", mem_addr_o, ad);
        e = model(op, cnt, pm, pw, pe, pg, ad, lock_mem[ad]);
        @(negedge clk);
        eof_i = 1'b0;
        check({start_prog_o, regular_read_o, block_read_o} == {e.sp, e.rr, e.br}, e.tag,
              "decision R1", {start_prog_o, regular_read_o, block_read_o}, {e.sp, e.rr, e.br});
        check(page_o == e.page && addr_o == e.addr, e.tag, "page/addr",
              {page_o, addr_o}, {e.page, e.addr});
        check(data_o == dt && lock_o == lk, "R12", "data/lock", {lock_o, data_o}, {lk, dt});
        snap = {page_o, addr_o, data_o, lock_o, 1'b0};
        opcode_i = 2'($urandom); bit_cnt_i = 7'($urandom); data_i = $urandom;
        addr_i = 3'($urandom); page_i = 1'($urandom); lock_i = 1'($urandom);
        pulse_err_i = 1'($urandom);
        @(negedge clk);
        check({start_prog_o, regular_read_o, block_read_o} == 3'b000, "R1", "no pulse",
              {start_prog_o, regular_read_o, block_read_o}, 0);
        check({page_o, addr_o, data_o, lock_o, 1'b0} == snap, "R13", "hold",
              {page_o, addr_o, data_o, lock_o}, snap[37:1]);
    endtask

    initial begin
        #1000000;
        if (!done) begin
            n_errors++; n_checks++;
            $display("FAIL watchdog: actual=1 expected=0");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        bit [31:0] sp = 32'hA5C3_1E07;
        void'($urandom(32'd1234));
        foreach (lock_mem[i]) lock_mem[i] = 1'b0;
        lock_mem[5] = 1'b1; lock_mem[2] = 1'b1;
        repeat (3) @(negedge clk);
        check({start_prog_o, regular_read_o, block_read_o, page_o, addr_o, lock_o} == 0,
              "R1", "reset state", {start_prog_o, regular_read_o, block_read_o, addr_o}, 0);
        rst_n = 1'b1;
        frame(2'b10, 70, 1, sp, 0, 1, 3'd3, 32'h1234_5678, 1);       // R3 ok
        frame(2'b10, 70, 0, sp, 0, 0, 3'd3, 32'hCAFE_0001, 0);       // R3 pwd off -> err
        frame(2'b10, 38, 0, 0, 0, 1, 3'd4, 32'hDEAD_BEEF, 0);        // R4
        frame(2'b10, 38, 0, 0, 0, 0, 3'd5, 32'h0F0F_0F0F, 0);        // R11 locked
        frame(2'b10, 70, 1, sp, 0, 1, 3'd2, 32'h7777_0000, 1);       // R11 locked pwd
        frame(2'b10, 38, 1, sp, 0, 0, 3'd6, 32'h1, 0);               // R5 direct pwd
        frame(2'b10, 6, 0, 32'h9999, 0, 1, 3'd2, 32'h2, 0);          // R5 pwd ignored
        frame(2'b10, 34, 1, sp, 0, 1, 3'd0, 32'h3, 0);               // R6
        frame(2'b10, 34, 0, sp, 0, 1, 3'd0, 32'h3, 0);               // R6 err
        frame(2'b00, 2, 0, 0, 0, 1, 3'd7, 32'h4, 0);                 // R7 reset
        frame(2'b11, 2, 1, 0, 0, 1, 3'd7, 32'h5, 0);                 // R7 page read
        frame(2'b10, 2, 0, 0, 0, 1, 3'd7, 32'h6, 0);                 // R7 err
        frame(2'b01, 2, 0, 0, 0, 1, 3'd4, 32'h7, 0);                 // R2 undefined
        frame(2'b10, 70, 1, sp ^ 32'h100, 0, 1, 3'd3, 32'h8, 0);     // R8 mismatch
        frame(2'b10, 38, 1, sp ^ 32'h8000_0000, 0, 0, 3'd6, 32'h9, 0); // R8
        frame(2'b10, 38, 0, 0, 1, 1, 3'd4, 32'hA, 0);                // R9 pulse err
        for (int k = 0; k < 400; k++) begin
            int lens[6] = '{2, 6, 34, 38, 70, 0};
            int cnt = lens[$urandom % 6];
            if (cnt == 0) cnt = $urandom % 128;
            frame(2'($urandom), cnt, 1'($urandom),
                  ($urandom % 2) ? sp : 32'($urandom), ($urandom % 8) == 0,
                  1'($urandom), 3'($urandom), 32'($urandom), 1'($urandom));
        end
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule